// File: doc/BRIEF.md
# Inline Crypto Keyslot Configuration Register Bank

This block holds the per-slot configurations for an inline storage encryption engine. Software programs each slot through a plain 32-bit register bus: a 64-byte key, a one-hot data-unit-size code, the index of the capability entry (algorithm and key size) the slot uses, and an enable flag. The same address space exposes a read-only capability word and a read-only table of capability entries. These tell software how many slots exist, where the slot array sits in the map, and which algorithm, data-unit-size and key-size combinations the engine supports. Capability entries carry the algorithm code in bits [7:0] (0 = AES-XTS, 1 = disk-volume AES-CBC, 2 = AES-ECB, 3 = ESSIV AES-CBC), a supported data-unit-size mask in bits [15:8], and a key-size code in bits [23:16] (1 = 128, 2 = 192, 3 = 256, 4 = 512 bits, 0 = invalid).

The cipher datapath reads a slot through a combinational lookup port by slot number. It receives the full 512-bit key field, the data-unit-size code, the capability index and a valid flag. A slot only turns valid when its control dword is written with the enable bit set after all sixteen key dwords have been written since the previous control-dword write. A half-programmed key can therefore never reach the datapath. An enable attempt that breaks this order leaves the slot off and sets a sticky sequence-error flag. Keys cannot be read back over the bus.

For XTS, software places the two key halves at byte offsets 0 and 32 of the key field. Other algorithms pack the key from offset 0. The block stores the field as written. The data-unit-size code equals the unit size divided by 512, which gives one-hot values for power-of-two units from 512 bytes to 64 KiB.

Top module: `kslot_cfg_regs`

## Requirements
- R1: The byte address 0x000 reads the capability word {ARRAY_PTR in [31:24], zero in [23:16], NUM_SLOTS-1 in [15:8], NUM_CAPS in [7:0]}. The byte address 0x004+4*i reads capability entry i, which is bits [32i+31:32i] of CAP_TABLE. Every other address below the slot array reads zero. Writes to any of these addresses change nothing.
- R2: Slot s occupies the 128 bytes at ARRAY_PTR*0x100 + s*0x80, with dword d at byte offset 4*d. Dwords 18 to 31 of a slot, and all addresses past the last slot, read zero and ignore writes.
- R3: Key dwords 0 to 15 of a slot accept writes, but every read of them returns zero.
- R4: Control dword 16 reads back as {enable in bit 31, zero in [30:16], capability index in [15:8], data-unit-size code in [7:0]}. Dword 17 stores all 32 bits written and reads them back.
- R5: A write to dword 16 stores bits [15:0]. It enables the slot only if bit 31 is set and all 16 key dwords of that slot were written since the previous write to dword 16. Otherwise the slot ends disabled. Every write to dword 16 restarts the key-write tracking.
- R6: A write to any key dword of a slot disables that slot from the next cycle on.
- R7: An enable attempt that R5 rejects raises seq_err one cycle later. seq_err stays high until reset.
- R8: When lk_slot < NUM_SLOTS, the lookup port gives that slot's enable as lk_valid, its key as lk_key (key dword d in bits [32d+31:32d]), its data-unit-size code and its capability index. When lk_slot >= NUM_SLOTS, all lookup outputs are zero.
- R9: Reset clears every slot's key, control fields, enable, vendor dword and key-write tracking, and clears seq_err.
- R10: Writing zero to all dwords of an enabled slot (eviction) leaves it disabled, with a zero key and zero control fields at the lookup port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte address (low two bits ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| lk_slot | input | 8 | Slot number requested by the datapath |
| lk_valid | output | 1 | Requested slot exists and is enabled |
| lk_key | output | 512 | Key field of the requested slot |
| lk_dus | output | 8 | Data-unit-size code of the requested slot |
| lk_cap | output | 8 | Capability index of the requested slot |
| seq_err | output | 1 | Sticky flag for a rejected enable |

## Verification
The hardest state to reach is an enable written on top of a key that is only partly refreshed. This means a slot that was valid, then had some key dwords rewritten or skipped, then got its enable bit again. The stimulus builds this on purpose. It programs slots fully, rewrites one key dword of an enabled slot, issues an enable after only some of the key dwords, and then repeats the full sequence. The behavioural model tracks the per-slot write history, and the lookup port is swept over valid and out-of-range slot numbers on every clock, so each of these transitions is seen at the datapath side.

// File: rtl/kslot_pkg.sv
package kslot_pkg;
   localparam int KEY_DWORDS = 16;
   localparam int CTL_DW     = 16;
   localparam int VND_DW     = 17;
   localparam int SLOT_BYTES = 128;
   localparam int IDX_W      = 8;
   localparam int KEY_BITS   = KEY_DWORDS * 32;

   typedef struct packed {
      logic       en;
      logic [7:0] cap;
      logic [7:0] dus;
   } slot_ctl_t;

   function automatic logic [31:0] ctl_word(input slot_ctl_t c);
      return {c.en, 15'b0, c.cap, c.dus};
   endfunction
endpackage

// File: rtl/kslot_decode.sv
module kslot_decode #(
   parameter int ADDR_W    = 12,
   parameter int NUM_SLOTS = 4,
   parameter int NUM_CAPS  = 2,
   parameter int BASE      = 512
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic                 capword_hit,
   output logic                 capent_hit,
   output logic [7:0]           capent_idx,
   output logic [NUM_SLOTS-1:0] slot_sel,
   output logic [4:0]           slot_dw
);
   localparam int unsigned LIMIT = BASE + NUM_SLOTS * kslot_pkg::SLOT_BYTES;

   int unsigned a;
   int unsigned word;
   int unsigned rel;
   logic        in_arr;

   always_comb begin
      a           = 32'(addr);
      word        = a >> 2;
      capword_hit = (word == 0);
      capent_hit  = (word >= 1) && (word <= NUM_CAPS);
      capent_idx  = 8'(word - 1);
      in_arr      = (a >= BASE) && (a < LIMIT);
      rel         = a - BASE;
      slot_dw     = 5'(rel >> 2);
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
      assign slot_sel[g] = in_arr && ((rel >> 7) == g);
   end
endmodule

// File: rtl/kslot_entry.sv
module kslot_entry
   import kslot_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel,
   input  logic                  wr,
   input  logic [4:0]            dw,
   input  logic [31:0]           wdata,
   output logic [KEY_BITS-1:0]   key_o,
   output slot_ctl_t             ctl_o,
   output logic [31:0]           rdata_o,
   output logic                  reject_o
);
   logic [KEY_DWORDS-1:0][31:0] key_q;
   logic [KEY_DWORDS-1:0]       seen_q;
   slot_ctl_t                   ctl_q;
   logic [31:0]                 vnd_q;
   logic                        key_we, ctl_we, vnd_we;
   logic                        unused_bits;

   assign key_we      = sel && wr && (dw < 5'(KEY_DWORDS));
   assign ctl_we      = sel && wr && (dw == 5'(CTL_DW));
   assign vnd_we      = sel && wr && (dw == 5'(VND_DW));
   assign unused_bits = ^wdata[30:16];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q  <= '0;
         seen_q <= '0;
         ctl_q  <= '0;
         vnd_q  <= '0;
      end else begin
         if (key_we) begin
            key_q[dw[3:0]]  <= wdata;
            seen_q[dw[3:0]] <= 1'b1;
            ctl_q.en        <= 1'b0;
         end
         if (ctl_we) begin
            ctl_q.dus <= wdata[7:0];
            ctl_q.cap <= wdata[15:8];
            ctl_q.en  <= wdata[31] && (&seen_q);
            seen_q    <= '0;
         end
         if (vnd_we) vnd_q <= wdata;
      end
   end

   assign reject_o = ctl_we && wdata[31] && !(&seen_q);
   assign key_o    = key_q;
   assign ctl_o    = ctl_q;

   always_comb begin
      rdata_o = '0;
      if (sel && dw == 5'(CTL_DW)) rdata_o = ctl_word(ctl_q);
      if (sel && dw == 5'(VND_DW)) rdata_o = vnd_q;
   end

   // R5
   en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_q.en) |-> $past(ctl_we && wdata[31] && (&seen_q)));
   // R6
   key_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_we |=> !ctl_q.en);
   // R3
   key_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && dw < 5'(KEY_DWORDS)) |-> (rdata_o == '0));
endmodule

// File: rtl/kslot_cfg_regs.sv
module kslot_cfg_regs
   import kslot_pkg::*;
#(
   parameter int                      ADDR_W    = 12,
   parameter int                      NUM_SLOTS = 4,
   parameter int                      NUM_CAPS  = 2,
   parameter logic [7:0]              ARRAY_PTR = 8'h02,
   parameter logic [NUM_CAPS*32-1:0]  CAP_TABLE = 64'h0001_0102_0003_0800
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [IDX_W-1:0]     lk_slot,
   output logic                 lk_valid,
   output logic [KEY_BITS-1:0]  lk_key,
   output logic [7:0]           lk_dus,
   output logic [7:0]           lk_cap,
   output logic                 seq_err
);
   localparam int BASE  = int'(ARRAY_PTR) * 256;
   localparam int LIMIT = BASE + NUM_SLOTS * SLOT_BYTES;

   if (NUM_SLOTS < 1 || NUM_SLOTS > 256) begin : g_bad_slots
      $error("NUM_SLOTS must lie in 1..256");
   end
   if (NUM_CAPS < 1 || NUM_CAPS > 255) begin : g_bad_caps
      $error("NUM_CAPS must lie in 1..255");
   end
   if (BASE < 4 * (NUM_CAPS + 1)) begin : g_overlap
      $error("slot array overlaps the capability table");
   end
   if (LIMIT > (1 << ADDR_W)) begin : g_range
      $error("slot array does not fit in the address space");
   end

   logic                 capword_hit, capent_hit;
   logic [7:0]           capent_idx;
   logic [NUM_SLOTS-1:0] slot_sel;
   logic [4:0]           slot_dw;
   logic [NUM_SLOTS-1:0] reject;
   logic [KEY_BITS-1:0]  key_arr [NUM_SLOTS];
   slot_ctl_t            ctl_arr [NUM_SLOTS];
   logic [31:0]          rd_arr  [NUM_SLOTS];
   logic                 seq_err_q;

   kslot_decode #(
      .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .NUM_CAPS(NUM_CAPS), .BASE(BASE)
   ) u_dec (
      .addr(bus_addr), .capword_hit(capword_hit), .capent_hit(capent_hit),
      .capent_idx(capent_idx), .slot_sel(slot_sel), .slot_dw(slot_dw)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      kslot_entry u_ent (
         .clk(clk), .rst_n(rst_n), .sel(slot_sel[s]), .wr(bus_wr),
         .dw(slot_dw), .wdata(bus_wdata), .key_o(key_arr[s]),
         .ctl_o(ctl_arr[s]), .rdata_o(rd_arr[s]), .reject_o(reject[s])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seq_err_q <= 1'b0;
      else        seq_err_q <= seq_err_q | (|reject);
   end
   assign seq_err = seq_err_q;

   always_comb begin
      bus_rdata = '0;
      if (capword_hit)
         bus_rdata = {ARRAY_PTR, 8'h00, 8'(NUM_SLOTS - 1), 8'(NUM_CAPS)};
      else if (capent_hit)
         bus_rdata = CAP_TABLE[32 * 32'(capent_idx) +: 32];
      else
         for (int s = 0; s < NUM_SLOTS; s++) bus_rdata = bus_rdata | rd_arr[s];
   end

   always_comb begin
      lk_valid = 1'b0;
      lk_key   = '0;
      lk_dus   = '0;
      lk_cap   = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (32'(lk_slot) == s) begin
            lk_valid = ctl_arr[s].en;
            lk_key   = key_arr[s];
            lk_dus   = ctl_arr[s].dus;
            lk_cap   = ctl_arr[s].cap;
         end
      end
   end

   // R2
   slot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_sel));
   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> seq_err);
   // R7
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_err) |-> $past(|reject));
   // R8
   always_comb begin
      if (rst_n && 32'(lk_slot) >= NUM_SLOTS)
         lk_range_chk: assert (!lk_valid && lk_key == '0 && lk_dus == '0 && lk_cap == '0);
   end
endmodule

// File: tb/kslot_cfg_regs_test.sv
module kslot_cfg_regs_test;
   localparam int NS   = 4;
   localparam int BASE = 32'h200;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0;
   logic [11:0]  bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [7:0]   lk_slot = '0;
   logic         lk_valid;
   logic [511:0] lk_key;
   logic [7:0]   lk_dus, lk_cap;
   logic         seq_err;

   int vectors = 0;
   int misses  = 0;
   bit running = 1'b0;
   bit done    = 1'b0;

   logic [31:0] m_key  [NS][16];
   logic        m_seen [NS][16];
   logic [7:0]  m_dus  [NS];
   logic [7:0]  m_cap  [NS];
   logic        m_en   [NS];
   logic [31:0] m_vnd  [NS];
   logic        m_err;

   kslot_cfg_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lk_slot(lk_slot),
      .lk_valid(lk_valid), .lk_key(lk_key), .lk_dus(lk_dus), .lk_cap(lk_cap),
      .seq_err(seq_err)
   );

   always #10 clk = ~clk;

   task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic void mclear();
      for (int s = 0; s < NS; s++) begin
         for (int d = 0; d < 16; d++) begin m_key[s][d] = '0; m_seen[s][d] = 1'b0; end
         m_dus[s] = '0; m_cap[s] = '0; m_en[s] = 1'b0; m_vnd[s] = '0;
      end
      m_err = 1'b0;
   endfunction

   function automatic bit all_seen(input int s);
      for (int d = 0; d < 16; d++) if (!m_seen[s][d]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic void mwrite(input int a, input logic [31:0] v);
      int s, d;
      if (a < BASE || a >= BASE + NS * 128) return;
      s = (a - BASE) / 128;
      d = ((a - BASE) % 128) / 4;
      if (d < 16) begin
         m_key[s][d] = v; m_seen[s][d] = 1'b1; m_en[s] = 1'b0;
      end else if (d == 16) begin
         m_dus[s] = v[7:0]; m_cap[s] = v[15:8];
         if (v[31] && !all_seen(s)) m_err = 1'b1;
         m_en[s] = v[31] && all_seen(s);
         for (int k = 0; k < 16; k++) m_seen[s][k] = 1'b0;
      end else if (d == 17) begin
         m_vnd[s] = v;
      end
   endfunction

   function automatic logic [31:0] mread(input int a);
      int s, d;
      if (a / 4 == 0) return 32'h0200_0302;
      if (a / 4 == 1) return 32'h0003_0800;
      if (a / 4 == 2) return 32'h0001_0102;
      if (a < BASE || a >= BASE + NS * 128) return '0;
      s = (a - BASE) / 128;
      d = ((a - BASE) % 128) / 4;
      if (d == 16) return {m_en[s], 15'b0, m_cap[s], m_dus[s]};
      if (d == 17) return m_vnd[s];
      return '0;
   endfunction

   function automatic int sa(input int s, input int d);
      return BASE + s * 128 + d * 4;
   endfunction

   // Per-clock comparison of the lookup port and the error flag (R8, R7)
   always @(negedge clk) begin
      if (running) begin
         logic [511:0] ek;
         int ls;
         ls = int'(lk_slot);
         ek = '0;
         chk("R7 seq_err", 512'(seq_err), 512'(m_err));
         if (ls < NS) begin
            for (int d = 0; d < 16; d++) ek[32*d +: 32] = m_key[ls][d];
            chk("R8 lk_valid", 512'(lk_valid), 512'(m_en[ls]));
            chk("R8 lk_key", lk_key, ek);
            chk("R8 lk_dus", 512'(lk_dus), 512'(m_dus[ls]));
            chk("R8 lk_cap", 512'(lk_cap), 512'(m_cap[ls]));
         end else begin
            chk("R8 out-of-range lookup", {lk_key, lk_valid, lk_dus, lk_cap}, '0);
         end
         lk_slot = (ls == NS + 1) ? 8'd0 : (ls == NS ? 8'd200 : 8'(ls + 1));
         if (ls == 200) lk_slot = 8'd0;
      end
   end

   task automatic wr(input int a, input logic [31:0] v);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = v;
      @(posedge clk);
      mwrite(a, v);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, input string tag);
      @(negedge clk);
      bus_addr = 12'(a);
      #2 chk(tag, 512'(bus_rdata), 512'(mread(a)));
   endtask

   task automatic prog(input int s, input int nkeys, input logic [31:0] ctl, input logic [31:0] seed);
      wr(sa(s, 16), 32'h0);
      for (int d = 0; d < nkeys; d++) wr(sa(s, d), seed ^ (32'h0101_0101 * (d + 1)));
      wr(sa(s, 17), seed + 32'h77);
      wr(sa(s, 16), ctl);
   endtask

   task automatic do_reset();
      @(posedge clk);
      #1 rst_n = 1'b0;
      mclear();
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      mclear();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      running = 1'b1;

      // R9 reset state, R1 capability space
      rd(0, "R1 capability word");
      rd(4, "R1 capability entry 0");
      rd(8, "R1 capability entry 1");
      rd(12, "R1 unused address below array");
      for (int s = 0; s < NS; s++) rd(sa(s, 16), "R9 control dword after reset");
      chk("R9 seq_err after reset", 512'(seq_err), 512'(0));

      // R1 writes to read-only space have no effect
      wr(0, 32'hFFFF_FFFF);
      wr(4, 32'h1234_5678);
      wr(12, 32'hDEAD_BEEF);
      rd(0, "R1 capability word after write");
      rd(4, "R1 capability entry after write");
      rd(12, "R1 unused address after write");

      // R5 full sequence enables slot 1; R3 R4 readback
      prog(1, 16, 32'h8000_0108, 32'hA5A5_0000);
      rd(sa(1, 16), "R4 control readback enabled");
      rd(sa(1, 17), "R4 vendor dword readback");
      rd(sa(1, 0), "R3 key dword 0 hidden");
      rd(sa(1, 15), "R3 key dword 15 hidden");
      repeat (8) @(posedge clk);

      // R4 reserved bits of control dword read zero
      prog(3, 16, 32'hFFFF_2040, 32'h0BAD_F00D);
      rd(sa(3, 16), "R4 reserved control bits");

      // R5 R7 enable with missing key dword is rejected
      prog(2, 15, 32'h8000_0001, 32'h5555_0000);
      rd(sa(2, 16), "R5 rejected enable stays off");
      chk("R7 seq_err raised", 512'(seq_err), 512'(1));
      repeat (8) @(posedge clk);

      // R6 key write disables an enabled slot
      wr(sa(1, 5), 32'h0000_1111);
      rd(sa(1, 16), "R6 key write drops enable");
      // R5 re-enable with only one fresh key dword after the last control write
      wr(sa(1, 16), 32'h8000_0108);
      rd(sa(1, 16), "R5 partial rewrite rejected");
      // R5 full sequence re-enables; R7 stays set
      prog(1, 16, 32'h8000_0110, 32'h3C3C_0000);
      rd(sa(1, 16), "R5 full rewrite enables");
      chk("R7 seq_err sticky", 512'(seq_err), 512'(1));

      // R5 enable bit clear leaves slot off without error in model
      prog(0, 16, 32'h0000_0104, 32'h1357_0000);
      rd(sa(0, 16), "R5 control write without enable");
      prog(0, 16, 32'h8000_0104, 32'h2468_0000);
      rd(sa(0, 16), "R5 slot 0 enabled");
      repeat (8) @(posedge clk);

      // R2 reserved dwords and out-of-array addresses
      wr(sa(0, 18), 32'hFFFF_FFFF);
      wr(sa(0, 31), 32'hFFFF_FFFF);
      rd(sa(0, 18), "R2 reserved dword 18");
      rd(sa(0, 31), "R2 reserved dword 31");
      wr(BASE + NS * 128, 32'hFFFF_FFFF);
      rd(BASE + NS * 128, "R2 past last slot");
      wr(32'h100, 32'h8000_0000);
      rd(32'h100, "R2 gap below array");
      rd(sa(0, 16), "R2 slot 0 untouched by stray writes");

      // R10 eviction of slot 1
      for (int d = 0; d < 32; d++) wr(sa(1, d), 32'h0);
      rd(sa(1, 16), "R10 evicted control dword");
      rd(sa(1, 17), "R10 evicted vendor dword");
      repeat (8) @(posedge clk);

      // R9 reset mid-run clears everything
      do_reset();
      repeat (2) @(posedge clk);
      rd(sa(0, 16), "R9 slot 0 after reset");
      rd(sa(3, 17), "R9 vendor after reset");
      chk("R9 seq_err cleared", 512'(seq_err), 512'(0));
      // R5 tracking cleared by reset: enable without keys is rejected
      wr(sa(2, 16), 32'h8000_0002);
      rd(sa(2, 16), "R9 tracking cleared by reset");
      repeat (8) @(posedge clk);

      running = 1'b0;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule